// File: doc/BRIEF.md
# Descriptor ROM Entry Walker

This block follows the chain of variable-length records that sits behind the header of a device descriptor image. A pulse on `start` gives it a starting byte position and an end position. It then fetches each record header through a synchronous byte read port with one cycle of latency. The first header byte is the record's total length, header included. The second byte holds the index, a disable flag and the record type. After each record, the walker moves forward by that length, until the position reaches the end.

Each record is either generic or port. A generic record is handed out with its index, the address of its first payload byte and its payload length. For an enabled port record, two more bytes are fetched to decode the link number, the dual-link flag and the dual-link partner port. A disabled port record is handed out with only its disable status set. A port record whose index is above the static `max_port` input is dropped without any output, and the walk goes on. Decoded records leave through a valid/ready output. `ent_valid` stays high and every `ent_*` field stays frozen until the consumer raises `ent_ready`. While a record is waiting, no further memory reads are issued.

A walk ends with a one-cycle `done` pulse or a one-cycle `err` pulse, never both. `err_len` tells whether the failure was a chain overrun or a bad port record length.

Top module: `rom_entry_walker`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `ent_valid` and `rd_en` are all 0.
- R2: For the header byte at position+1: bits 5:0 appear on `ent_index`, and bit 7 appears on `ent_is_port` (1 = port, 0 = generic). Bit 6 appears on `ent_disabled` only for port records; generic records show `ent_disabled` = 0.
- R3: The walk ends with `err`=1 and `err_len`=0 in three cases: position+1 equals the end, the length byte is 0, or position+length exceeds the end.
- R4: A generic record is handed out with `ent_pay_start` = position+2 and `ent_pay_len` = length-2. For a length of 1, `ent_pay_len` is 0.
- R5: A port record with index greater than `max_port` produces no output, and the walk continues with the next record.
- R6: A disabled port record is handed out with `ent_disabled`=1, and `ent_link`, `ent_has_dual` and `ent_dual_port` all 0. No length check is applied to it.
- R7: An enabled, in-range port record whose length is not 8 ends the walk with `err`=1 and `err_len`=1, and produces no output.
- R8: An enabled port record of length 8 is decoded as follows: `ent_link` = byte2 bit 4, `ent_has_dual` = byte2 bit 7, and `ent_dual_port` = byte3 bits 5:0. Byte3 bits 7:6 are ignored.
- R9: The next position is the current position plus the length. Once the position is at or past the end, the walk ends with `done`=1. An empty chain (start = end) finishes with no reads.
- R10: `done` and `err` are single-cycle pulses, are never high together, and occur once per accepted `start`.
- R11: While `ent_valid`=1 and `ent_ready`=0, `ent_valid` and all `ent_*` fields hold their values, and `rd_en` stays 0.
- R12: Each fetched byte costs exactly one `rd_en` cycle, and read data is taken one cycle after the request. A `start` pulse that arrives while `busy`=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| start_pos | input | AW | Byte position of the first record |
| end_pos | input | AW | Byte position where the chain ends |
| max_port | input | 6 | Highest port index that is accepted (static) |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | AW | Memory byte address |
| rd_data | input | 8 | Read data, valid one cycle after `rd_en` |
| ent_valid | output | 1 | A decoded record is on offer |
| ent_ready | input | 1 | Consumer accepts the record |
| ent_is_port | output | 1 | Record type: 1 port, 0 generic |
| ent_index | output | 6 | Record index |
| ent_disabled | output | 1 | Port record is disabled |
| ent_link | output | 1 | Link number of an enabled port |
| ent_has_dual | output | 1 | Port has a dual-link partner |
| ent_dual_port | output | 6 | Dual-link partner port number |
| ent_pay_start | output | AW | Position of the first payload byte |
| ent_pay_len | output | 8 | Payload length in bytes |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Walk completed (one-cycle pulse) |
| err | output | 1 | Walk failed (one-cycle pulse) |
| err_len | output | 1 | Failure cause: 1 bad port length, 0 overrun |

## Verification
Two functions can collide around the last record: the handover of that record under back-pressure, and the end-of-chain test that raises `done`. A second pair is a fresh `start` arriving while the walk is busy. The bench checks both with one chain. It ends exactly at the end position and mixes a skipped port, a disabled port and a fully decoded port. The first record is held back for several cycles, and a `start` aimed at a different region is injected mid-walk. The run is judged correct only if all of the following hold: the fields stay frozen while stalled; exactly three records come out; the read count matches the bytes the requirements call for; and exactly one `done` follows the last handshake.

// File: rtl/walker_pkg.sv
package walker_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 6;

  // header byte 1 field positions (decoded by neighbours)
  localparam int HDR_TYPE_BIT = 7;
  localparam int HDR_DIS_BIT  = 6;
  // port record byte 2 field positions
  localparam int PB2_LINK_BIT = 4;
  localparam int PB2_DUAL_BIT = 7;

  typedef enum logic [2:0] {
    W_IDLE,
    W_CHECK,
    W_LEN,
    W_HDR,
    W_B2,
    W_B3,
    W_EMIT
  } walk_state_e;

  typedef struct packed {
    logic              is_port;
    logic [IDX_W-1:0]  index;
    logic              disabled;
    logic              link;
    logic              has_dual;
    logic [IDX_W-1:0]  dual_port;
    logic [BYTE_W-1:0] pay_len;
  } entry_fields_t;
endpackage

// File: rtl/walker_hop_check.sv
module walker_hop_check
  import walker_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]     pos,
  input  logic [AW-1:0]     end_pos,
  input  logic [BYTE_W-1:0] len,
  output logic              at_end,
  output logic              tail_hit,
  output logic              len_bad,
  output logic [AW-1:0]     next_pos
);
  localparam int XW = AW + 1;

  logic [XW-1:0] pos_x;
  logic [XW-1:0] end_x;
  logic [XW-1:0] len_x;
  logic [XW-1:0] pos_plus_one;
  logic [XW-1:0] pos_plus_len;

  always_comb begin
    pos_x        = {1'b0, pos};
    end_x        = {1'b0, end_pos};
    len_x        = {{(XW-BYTE_W){1'b0}}, len};
    pos_plus_one = pos_x + {{(XW-1){1'b0}}, 1'b1};
    pos_plus_len = pos_x + len_x;
    at_end       = (pos_x >= end_x);
    tail_hit     = (pos_plus_one == end_x);
    len_bad      = (len == '0) || (pos_plus_len > end_x);
    next_pos     = pos_plus_len[AW-1:0];
  end
endmodule

// File: rtl/walker_hdr_decode.sv
module walker_hdr_decode
  import walker_pkg::*;
(
  input  logic [BYTE_W-1:0] len,
  input  logic [BYTE_W-1:0] hdr,
  input  logic              b2_link,
  input  logic              b2_dual,
  input  logic [IDX_W-1:0]  b3_port,
  input  logic              full,
  output entry_fields_t     fields
);
  always_comb begin
    fields.is_port   = hdr[HDR_TYPE_BIT];
    fields.index     = hdr[IDX_W-1:0];
    fields.disabled  = hdr[HDR_TYPE_BIT] & hdr[HDR_DIS_BIT];
    fields.link      = full ? b2_link : 1'b0;
    fields.has_dual  = full ? b2_dual : 1'b0;
    fields.dual_port = full ? b3_port : '0;
    fields.pay_len   = (len < BYTE_W'(2)) ? '0 : (len - BYTE_W'(2));
  end
endmodule

// File: rtl/walker_out_slice.sv
module walker_out_slice
  import walker_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  entry_fields_t f_in,
  input  logic [AW-1:0] ps_in,
  input  logic          ready,
  output logic          valid,
  output entry_fields_t f_out,
  output logic [AW-1:0] ps_out,
  output logic          accept
);
  assign accept = valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      f_out  <= '0;
      ps_out <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      f_out  <= f_in;
      ps_out <= ps_in;
    end else if (accept) begin
      valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/rom_entry_walker.sv
module rom_entry_walker
  import walker_pkg::*;
#(
  parameter int AW       = 16,
  parameter int PORT_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_pos,
  input  logic [AW-1:0]     end_pos,
  input  logic [IDX_W-1:0]  max_port,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              ent_valid,
  input  logic              ent_ready,
  output logic              ent_is_port,
  output logic [IDX_W-1:0]  ent_index,
  output logic              ent_disabled,
  output logic              ent_link,
  output logic              ent_has_dual,
  output logic [IDX_W-1:0]  ent_dual_port,
  output logic [AW-1:0]     ent_pay_start,
  output logic [BYTE_W-1:0] ent_pay_len,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              err_len
);
  localparam logic [BYTE_W-1:0] PLEN = BYTE_W'(PORT_LEN);

  walk_state_e       state;
  logic [AW-1:0]     pos_q;
  logic [AW-1:0]     end_q;
  logic [BYTE_W-1:0] len_q;
  logic [BYTE_W-1:0] hdr_q;
  logic              b2_link_q;
  logic              b2_dual_q;
  logic              done_q;
  logic              err_q;
  logic              err_len_q;

  logic              at_end;
  logic              tail_hit;
  logic              len_bad;
  logic [AW-1:0]     next_pos;

  logic [BYTE_W-1:0] hdr_sel;
  logic              full_dec;
  entry_fields_t     dec_fields;
  entry_fields_t     out_fields;
  logic              load;
  logic              accept;
  logic [1:0]        rd_off;

  logic              hdr_port;
  logic              hdr_dis;
  logic              hdr_oor;
  logic              hdr_len_ok;

  walker_hop_check #(.AW(AW)) u_hop (
    .pos      (pos_q),
    .end_pos  (end_q),
    .len      (len_q),
    .at_end   (at_end),
    .tail_hit (tail_hit),
    .len_bad  (len_bad),
    .next_pos (next_pos)
  );

  assign hdr_sel  = (state == W_HDR) ? rd_data : hdr_q;
  assign full_dec = (state == W_B3);

  walker_hdr_decode u_dec (
    .len     (len_q),
    .hdr     (hdr_sel),
    .b2_link (b2_link_q),
    .b2_dual (b2_dual_q),
    .b3_port (rd_data[IDX_W-1:0]),
    .full    (full_dec),
    .fields  (dec_fields)
  );

  // classification of the header byte arriving in W_HDR
  assign hdr_port   = rd_data[HDR_TYPE_BIT];
  assign hdr_dis    = rd_data[HDR_DIS_BIT];
  assign hdr_oor    = rd_data[IDX_W-1:0] > max_port;
  assign hdr_len_ok = (len_q == PLEN);

  // load the output slice for generic, disabled-port and decoded-port records
  always_comb begin
    load = 1'b0;
    if (state == W_HDR && !len_bad) begin
      if (!hdr_port)                 load = 1'b1;
      else if (!hdr_oor && hdr_dis)  load = 1'b1;
    end else if (state == W_B3) begin
      load = 1'b1;
    end
  end

  // read requests: one per byte, address = position + byte offset
  always_comb begin
    rd_en  = 1'b0;
    rd_off = 2'd0;
    unique case (state)
      W_CHECK: begin
        rd_en  = !at_end && !tail_hit;
        rd_off = 2'd0;
      end
      W_LEN: begin
        rd_en  = 1'b1;
        rd_off = 2'd1;
      end
      W_HDR: begin
        rd_en  = !len_bad && hdr_port && !hdr_oor && !hdr_dis && hdr_len_ok;
        rd_off = 2'd2;
      end
      W_B2: begin
        rd_en  = 1'b1;
        rd_off = 2'd3;
      end
      default: begin
        rd_en  = 1'b0;
        rd_off = 2'd0;
      end
    endcase
  end

  assign rd_addr = pos_q + {{(AW-2){1'b0}}, rd_off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= W_IDLE;
      pos_q     <= '0;
      end_q     <= '0;
      len_q     <= '0;
      hdr_q     <= '0;
      b2_link_q <= 1'b0;
      b2_dual_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      err_len_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state)
        W_IDLE: begin
          if (start) begin
            pos_q <= start_pos;
            end_q <= end_pos;
            state <= W_CHECK;
          end
        end
        W_CHECK: begin
          if (at_end) begin
            done_q <= 1'b1;
            state  <= W_IDLE;
          end else if (tail_hit) begin
            err_q     <= 1'b1;
            err_len_q <= 1'b0;
            state     <= W_IDLE;
          end else begin
            state <= W_LEN;
          end
        end
        W_LEN: begin
          len_q <= rd_data;
          state <= W_HDR;
        end
        W_HDR: begin
          hdr_q <= rd_data;
          if (len_bad) begin
            err_q     <= 1'b1;
            err_len_q <= 1'b0;
            state     <= W_IDLE;
          end else if (!hdr_port) begin
            state <= W_EMIT;
          end else if (hdr_oor) begin
            pos_q <= next_pos;
            state <= W_CHECK;
          end else if (hdr_dis) begin
            state <= W_EMIT;
          end else if (!hdr_len_ok) begin
            err_q     <= 1'b1;
            err_len_q <= 1'b1;
            state     <= W_IDLE;
          end else begin
            state <= W_B2;
          end
        end
        W_B2: begin
          b2_link_q <= rd_data[PB2_LINK_BIT];
          b2_dual_q <= rd_data[PB2_DUAL_BIT];
          state     <= W_B3;
        end
        W_B3: begin
          state <= W_EMIT;
        end
        W_EMIT: begin
          if (accept) begin
            pos_q <= next_pos;
            state <= W_CHECK;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  walker_out_slice #(.AW(AW)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .f_in   (dec_fields),
    .ps_in  (pos_q + AW'(2)),
    .ready  (ent_ready),
    .valid  (ent_valid),
    .f_out  (out_fields),
    .ps_out (ent_pay_start),
    .accept (accept)
  );

  assign ent_is_port   = out_fields.is_port;
  assign ent_index     = out_fields.index;
  assign ent_disabled  = out_fields.disabled;
  assign ent_link      = out_fields.link;
  assign ent_has_dual  = out_fields.has_dual;
  assign ent_dual_port = out_fields.dual_port;
  assign ent_pay_len   = out_fields.pay_len;

  assign busy    = (state != W_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign err_len = err_len_q;
endmodule

// File: rtl/walker_sva.sv
module walker_sva
  import walker_pkg::*;
#(
  parameter int AW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              err,
  input logic              busy,
  input logic              rd_en,
  input logic              ent_valid,
  input logic              ent_ready,
  input logic              ent_is_port,
  input logic [IDX_W-1:0]  ent_index,
  input logic              ent_disabled,
  input logic              ent_link,
  input logic              ent_has_dual,
  input logic [IDX_W-1:0]  ent_dual_port,
  input logic [AW-1:0]     ent_pay_start,
  input logic [BYTE_W-1:0] ent_pay_len,
  input logic [IDX_W-1:0]  max_port
);
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_ready) |=> (ent_valid && $stable({ent_is_port, ent_index,
      ent_disabled, ent_link, ent_has_dual, ent_dual_port, ent_pay_start, ent_pay_len}))); // R11

  AST_NO_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> !rd_en); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_en); // R12

  AST_DISABLED_BARE: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_disabled) |-> (!ent_link && !ent_has_dual && ent_dual_port == '0)); // R6

  AST_PORT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_is_port) |-> (ent_index <= max_port)); // R5

  AST_DONE_AFTER_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ent_valid); // R9
endmodule

bind rom_entry_walker walker_sva #(.AW(AW)) u_sva (.*);

// File: tb/tb_rom_entry_walker.sv
`timescale 1ns/1ps
module tb_rom_entry_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] start_pos;
  logic [15:0] end_pos;
  logic [5:0]  max_port;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic        ent_valid;
  logic        ent_ready;
  logic        ent_is_port;
  logic [5:0]  ent_index;
  logic        ent_disabled;
  logic        ent_link;
  logic        ent_has_dual;
  logic [5:0]  ent_dual_port;
  logic [15:0] ent_pay_start;
  logic [7:0]  ent_pay_len;
  logic        busy;
  logic        done;
  logic        err;
  logic        err_len;

  always #2.5 clk = ~clk;

  rom_entry_walker dut (.*);

  logic [7:0] mem [256];
  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[7:0]];

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0] b0, b1, b2, b3, eo;
    logic [5:0] mp;
    logic       emit, port;
    logic [5:0] idx;
    logic       dis, link, dual;
    logic [5:0] dp;
    logic [7:0] pl;
    logic [1:0] res;  // 0 done, 1 overrun, 2 bad port length
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'd5, 8'h01, 8'hAA, 8'hBB, 8'd5, 6'd5, 1'b1, 1'b0, 6'd1, 1'b0, 1'b0, 1'b0, 6'd0,  8'd3, 2'd0},
    '{8'd1, 8'h02, 8'h00, 8'h00, 8'd2, 6'd5, 1'b1, 1'b0, 6'd2, 1'b0, 1'b0, 1'b0, 6'd0,  8'd0, 2'd1},
    '{8'd0, 8'h01, 8'h00, 8'h00, 8'd4, 6'd5, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 6'd0,  8'd0, 2'd1},
    '{8'd6, 8'h01, 8'h00, 8'h00, 8'd4, 6'd5, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 6'd0,  8'd0, 2'd1},
    '{8'd8, 8'h83, 8'h90, 8'h05, 8'd8, 6'd5, 1'b1, 1'b1, 6'd3, 1'b0, 1'b1, 1'b1, 6'd5,  8'd6, 2'd0},
    '{8'd8, 8'h86, 8'h90, 8'h05, 8'd8, 6'd5, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 6'd0,  8'd0, 2'd0},
    '{8'd3, 8'hC2, 8'hFF, 8'hFF, 8'd3, 6'd5, 1'b1, 1'b1, 6'd2, 1'b1, 1'b0, 1'b0, 6'd0,  8'd1, 2'd0},
    '{8'd6, 8'h82, 8'h00, 8'h00, 8'd6, 6'd5, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 6'd0,  8'd0, 2'd2},
    '{8'd8, 8'h85, 8'h0F, 8'hFF, 8'd8, 6'd5, 1'b1, 1'b1, 6'd5, 1'b0, 1'b0, 1'b0, 6'h3F, 8'd6, 2'd0},
    '{8'd8, 8'h84, 8'h10, 8'h40, 8'd8, 6'd5, 1'b1, 1'b1, 6'd4, 1'b0, 1'b1, 1'b0, 6'd0,  8'd6, 2'd0},
    '{8'd1, 8'h01, 8'h00, 8'h00, 8'd1, 6'd5, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 6'd0,  8'd0, 2'd1},
    '{8'd8, 8'hBF, 8'h80, 8'h01, 8'd8, 6'd63,1'b1, 1'b1, 6'd63,1'b0, 1'b0, 1'b1, 6'd1,  8'd6, 2'd0},
    '{8'd4, 8'h7F, 8'h00, 8'h00, 8'd4, 6'd0, 1'b1, 1'b0, 6'd63,1'b0, 1'b0, 1'b0, 6'd0,  8'd2, 2'd0}
  };

  // results of the latest walk
  int          n_emit, res_code, rd_cnt, done_cnt, err_cnt;
  logic        stall_bad, both_bad;
  logic        cap_port [8];
  logic [5:0]  cap_idx  [8];
  logic        cap_dis  [8];
  logic        cap_link [8];
  logic        cap_dual [8];
  logic [5:0]  cap_dp   [8];
  logic [15:0] cap_ps   [8];
  logic [7:0]  cap_pl   [8];

  task automatic run_walk(input logic [15:0] sp, input logic [15:0] ep, input logic [5:0] mp,
                          input int hold, input int poke);
    int held;
    logic was_stall;
    logic [39:0] prev;
    held = 0; was_stall = 1'b0; prev = '0;
    n_emit = 0; res_code = 3; rd_cnt = 0; done_cnt = 0; err_cnt = 0;
    stall_bad = 1'b0; both_bad = 1'b0;
    @(negedge clk);
    start_pos = sp; end_pos = ep; max_port = mp; start = 1'b1; ent_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 300; cyc++) begin
      start = (cyc == poke);
      if (cyc == poke) begin
        start_pos = 16'h0010;
        end_pos   = 16'h0011;
      end
      if (rd_en) rd_cnt++;
      if (done && err) both_bad = 1'b1;
      if (done) done_cnt++;
      if (err) err_cnt++;
      if (res_code == 3) begin
        if (done) res_code = 0;
        else if (err) res_code = err_len ? 2 : 1;
      end
      if (was_stall && (!ent_valid || prev != {ent_is_port, ent_index, ent_disabled, ent_link,
          ent_has_dual, ent_dual_port, ent_pay_start, ent_pay_len}))
        stall_bad = 1'b1;
      ent_ready = 1'b1;
      if (ent_valid && held < hold) begin
        ent_ready = 1'b0;
        held++;
      end
      was_stall = ent_valid && !ent_ready;
      prev = {ent_is_port, ent_index, ent_disabled, ent_link, ent_has_dual, ent_dual_port,
              ent_pay_start, ent_pay_len};
      if (ent_valid && ent_ready) begin
        if (n_emit < 8) begin
          cap_port[n_emit] = ent_is_port;
          cap_idx[n_emit]  = ent_index;
          cap_dis[n_emit]  = ent_disabled;
          cap_link[n_emit] = ent_link;
          cap_dual[n_emit] = ent_has_dual;
          cap_dp[n_emit]   = ent_dual_port;
          cap_ps[n_emit]   = ent_pay_start;
          cap_pl[n_emit]   = ent_pay_len;
        end
        n_emit++;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog expired: actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    rst_n = 1'b0; start = 1'b0; ent_ready = 1'b0;
    start_pos = '0; end_pos = '0; max_port = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
    chk("R1", "err after reset", err, 0);
    chk("R1", "ent_valid after reset", ent_valid, 0);
    chk("R1", "rd_en after reset", rd_en, 0);

    // vector table: one record per image at 0x10
    for (int i = 0; i < NV; i++) begin
      for (int a = 16'h10; a < 16'h20; a++) mem[a] = 8'h00;
      mem[16'h10] = VECS[i].b0;
      mem[16'h11] = VECS[i].b1;
      mem[16'h12] = VECS[i].b2;
      mem[16'h13] = VECS[i].b3;
      run_walk(16'h0010, 16'h0010 + {8'h00, VECS[i].eo}, VECS[i].mp, 0, -1);
      chk(VECS[i].res == 2'd1 ? "R3" : (VECS[i].res == 2'd2 ? "R7" : "R9"),
          $sformatf("vec%0d walk result", i), res_code, VECS[i].res);
      chk("R5", $sformatf("vec%0d record count", i), n_emit, VECS[i].emit);
      chk("R10", $sformatf("vec%0d end pulses", i), done_cnt + err_cnt, 1);
      chk("R10", $sformatf("vec%0d done with err", i), both_bad, 0);
      if (VECS[i].emit) begin
        chk("R2", $sformatf("vec%0d type", i), cap_port[0], VECS[i].port);
        chk("R2", $sformatf("vec%0d index", i), cap_idx[0], VECS[i].idx);
        chk("R6", $sformatf("vec%0d disabled", i), cap_dis[0], VECS[i].dis);
        chk("R8", $sformatf("vec%0d link", i), cap_link[0], VECS[i].link);
        chk("R8", $sformatf("vec%0d dual flag", i), cap_dual[0], VECS[i].dual);
        chk("R8", $sformatf("vec%0d dual port", i), cap_dp[0], VECS[i].dp);
        if (!VECS[i].port) begin
          chk("R4", $sformatf("vec%0d payload start", i), cap_ps[0], 16'h0012);
          chk("R4", $sformatf("vec%0d payload length", i), cap_pl[0], VECS[i].pl);
        end
      end
    end

    // empty chain: start equals end
    run_walk(16'h0030, 16'h0030, 6'd5, 0, -1);
    chk("R9", "empty chain result", res_code, 0);
    chk("R9", "empty chain reads", rd_cnt, 0);
    chk("R9", "empty chain records", n_emit, 0);

    // chain: generic, skipped port, disabled port, decoded port; stall and mid-walk start
    for (int a = 16'h40; a < 16'h60; a++) mem[a] = 8'h00;
    mem[16'h40] = 8'd4; mem[16'h41] = 8'h01;
    mem[16'h44] = 8'd8; mem[16'h45] = 8'hA8; mem[16'h46] = 8'h90; mem[16'h47] = 8'h01;
    mem[16'h4C] = 8'd2; mem[16'h4D] = 8'hC1;
    mem[16'h4E] = 8'd8; mem[16'h4F] = 8'h82; mem[16'h50] = 8'h90; mem[16'h51] = 8'h07;
    run_walk(16'h0040, 16'h0056, 6'd5, 3, 4);
    chk("R9", "chain result", res_code, 0);
    chk("R5", "chain records after skip", n_emit, 3);
    chk("R11", "fields held under stall", stall_bad, 0);
    chk("R12", "chain read count", rd_cnt, 10);
    chk("R12", "single done despite mid-walk start", done_cnt, 1);
    chk("R10", "chain no error pulse", err_cnt, 0);
    chk("R4", "chain first payload start", cap_ps[0], 16'h0042);
    chk("R4", "chain first payload length", cap_pl[0], 2);
    chk("R6", "chain second is disabled", cap_dis[1], 1);
    chk("R2", "chain second index", cap_idx[1], 1);
    chk("R8", "chain third dual port", cap_dp[2], 7);
    chk("R9", "chain third payload start", cap_ps[2], 16'h0050);

    summary();
    $finish;
  end
endmodule